// File: doc/BRIEF.md
# Gated Tone Frequency Counter

This block estimates the pitch of a squared-up audio tone. It counts the rising edges of the tone inside a fixed gate window whose length is timed by the system clock. A band select picks the gate: a long gate for low-pitched tones and a gate one third as long for high-pitched ones. The low gate is about 39.5 ms and the high gate about 13.2 ms at a 3.579545 MHz reference. With these gates, every tone in either band gives a count that fits in six bits.

Upstream analogue stages send a signal-good qualifier. Whenever that qualifier drops, the measurement in flight is thrown away and the gate restarts. A change of band has the same effect. When a gate closes cleanly, the block latches the count and raises a one-cycle done strobe, which a host can use as an interrupt request. The next gate then opens at once.

Top module: `tone_freq_counter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `result` is 0 and `done` is 0.
- R2: `result` equals the number of rising edges of `sig_in` that fall inside the gate window, each one counted once. `sig_in` passes through a two-stage synchroniser before it is counted.
- R3: With `band_hi` = 0, `done` is high in the cycle that follows clock edge E + LO_GATE. E is the last clock edge at which the gate was restarted.
- R4: With `band_hi` = 1, the same rule holds with HI_GATE in place of LO_GATE.
- R5: `done` is high for exactly one cycle per window. `result` takes its new value in that same cycle and holds it until the next `done`.
- R6: A clock edge at which `sig_good` is 0 clears the count and restarts the gate. The window that was in progress produces no `done`.
- R7: A clock edge at which `band_hi` differs from its value at the previous edge restarts the gate in the same way. It also produces no `done` for the interrupted window.
- R8: A window holding more than 63 rising edges reports 63.
- R9: After a `done`, the next window starts at once from a count of zero. A window with no input edges therefore reports 0 one gate length later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also times the gate |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Squared-up tone, asynchronous to `clk` |
| band_hi | input | 1 | Band select: 1 = high band (short gate), 0 = low band (long gate) |
| sig_good | input | 1 | Signal quality qualifier; 0 aborts the measurement |
| result | output | 6 | Latched edge count of the last clean window |
| done | output | 1 | One-cycle strobe that marks a new `result` |

## Verification
On every cycle, the assertions check four things. `done` never lasts two cycles. `result` moves only together with `done`. A cycle with a bad qualifier or a band change is never followed by a `done`. The gate timer stays below the active gate length, and a saturated count stays at 63. Only the bench scenarios can show that the count matches the number of edges driven, that `done` lands exactly one gate length after a restart in each band, and that aborted windows vanish without a trace. Gate lengths are scaled down in the bench so that each window is a few hundred cycles.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int RES_W = 6;
  localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};
  typedef logic [RES_W-1:0] res_t;

  // saturating add of a single-bit increment
  function automatic res_t sat_inc(input res_t v, input logic inc);
    if (inc && v != RES_MAX) return v + res_t'(1);
    return v;
  endfunction
endpackage

// File: rtl/tfc_sync.sv
module tfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tfc_gate_timer.sv
module tfc_gate_timer #(
  parameter int TW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [TW-1:0] gate_len,
  output logic          win_end
);
  logic [TW-1:0] tmr;
  logic          last;

  assign last    = (tmr == gate_len - TW'(1));
  assign win_end = last & ~restart;

  always_ff @(posedge clk) begin
    if (rst || restart || last) tmr <= '0;
    else                        tmr <= tmr + TW'(1);
  end

  // R3 R4: the timer never runs past the active gate outside an abort
  tmr_in_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (tmr < gate_len));
endmodule

// File: rtl/tfc_cycle_counter.sv
module tfc_cycle_counter
  import tfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic clear,
  input  logic win_end,
  output res_t result,
  output logic done
);
  res_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= win_end;
      if (clear) begin
        cnt <= '0;
      end else if (win_end) begin
        result <= sat_inc(cnt, rise);
        cnt    <= '0;
      end else begin
        cnt <= sat_inc(cnt, rise);
      end
    end
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == RES_MAX && !clear && !win_end) |=> (cnt == RES_MAX));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/tone_freq_counter.sv
module tone_freq_counter
  import tfc_pkg::*;
#(
  parameter int LO_GATE     = 141285,
  parameter int HI_GATE     = 47095,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             band_hi,
  input  logic             sig_good,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int GMAX = (LO_GATE > HI_GATE) ? LO_GATE : HI_GATE;
  localparam int TW   = $clog2(GMAX + 1);

  logic          band_q;
  logic          abort;
  logic          rise;
  logic          win_end;
  logic [TW-1:0] gate_len;

  always_ff @(posedge clk) begin
    if (rst) band_q <= 1'b0;
    else     band_q <= band_hi;
  end

  assign abort    = ~sig_good | (band_hi ^ band_q);
  assign gate_len = band_hi ? TW'(HI_GATE) : TW'(LO_GATE);

  tfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sig_in), .rise(rise)
  );

  tfc_gate_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .restart(abort), .gate_len(gate_len), .win_end(win_end)
  );

  tfc_cycle_counter u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .clear(abort), .win_end(win_end),
    .result(result), .done(done)
  );

  // R6
  bad_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !sig_good |=> !done);
  // R7
  band_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (band_hi != $past(band_hi)) |=> !done);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: tb/tone_freq_counter_tb.sv
module tone_freq_counter_tb;
  localparam int LO = 300;
  localparam int HI = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic band_hi = 1'b0;
  logic sig_good = 1'b0;
  logic [5:0] result;
  logic done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int pushed = 0;
  int popped = 0;
  int next_start = 0;
  int exp_val[$];
  int exp_cyc[$];
  int last_val = 0;
  int chk_hold = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_freq_counter #(.LO_GATE(LO), .HI_GATE(HI)) u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .band_hi(band_hi),
    .sig_good(sig_good), .result(result), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (!rst) begin
      if (chk_hold != 0) begin
        chk_hold = 0;
        check("R5 done one cycle", int'(done), 0);
        if (!done) check("R5 result held", int'(result), last_val);
      end
      if (done) begin
        if (exp_val.size() == 0) begin
          check("R6/R7 unexpected done", 1, 0);
        end else begin
          check("R2 count", int'(result), exp_val[0]);
          check("R3/R4 done cycle", cyc, exp_cyc[0]);
          last_val = exp_val[0];
          void'(exp_val.pop_front());
          void'(exp_cyc.pop_front());
          popped++;
        end
        chk_hold = 1;
      end
    end
  end

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1; repeat (2) @(negedge clk);
      sig_in = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  // restart the gate and return the edge number at which it restarts
  task automatic open_win(input logic hi, input bit via_band, output int st);
    @(negedge clk);
    band_hi = hi;
    if (!via_band) sig_good = 1'b0;
    st = cyc + 1;
    @(negedge clk);
    sig_good = 1'b1;
  endtask

  task automatic measure(input logic hi, input int n, input bit via_band);
    int st;
    int g;
    g = hi ? HI : LO;
    open_win(hi, via_band, st);
    exp_val.push_back(n > 63 ? 63 : n);
    exp_cyc.push_back(st + g);
    pushed++;
    pulses(n);
    wait (popped == pushed);
    next_start = st + g;
  endtask

  task automatic partial(input logic hi, input int n, input bit via_band);
    int st;
    open_win(hi, via_band, st);
    pulses(n);
  endtask

  // R9: the next window begins right after done, empty here
  task automatic empty_next(input logic hi);
    int g;
    g = hi ? HI : LO;
    exp_val.push_back(0);
    exp_cyc.push_back(next_start + g);
    pushed++;
    wait (popped == pushed);
    next_start = next_start + g;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", int'(result), 0);
    check("R1 done in reset", int'(done), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 result after reset", int'(result), 0);
    check("R1 done after reset", int'(done), 0);

    measure(1'b0, 10, 1'b0);  // R2 R3
    empty_next(1'b0);         // R9
    measure(1'b1, 15, 1'b0);  // R4
    empty_next(1'b1);         // R9
    partial(1'b0, 5, 1'b0);   // R6: abandoned by the next restart
    measure(1'b0, 12, 1'b0);  // R6
    partial(1'b1, 8, 1'b0);
    measure(1'b0, 20, 1'b1);  // R7: band change alone restarts
    measure(1'b0, 70, 1'b0);  // R8
    measure(1'b0, 64, 1'b0);  // R8
    measure(1'b0, 63, 1'b0);  // R8 edge
    measure(1'b1, 20, 1'b0);  // R4
    measure(1'b1, 1, 1'b0);   // R2

    sig_good = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule